// File: doc/BRIEF.md
# Ingress Frame Guard for a Packet Switch Port

This block sits between a packet-stream source (an application buffer or a MAC receive path) and the ingress of a switch. Both sides use a valid/ready beat stream. Each beat carries a data word, per-byte enables, start and end markers and an error flag. The block makes sure the switch never sees a malformed frame, and that a broken or stalled source can never hold the switch in a half-finished transfer.

Broken framing is repaired in two ways:
- **Missing end marker.** If a new start marker arrives while a frame is still open, the new beats are appended to the open frame. The merged frame carries the error flag through to its last beat, so the egress side can signal a transmit error.
- **Enable withdrawn mid-frame.** If the receive enable is dropped while a frame is open downstream, the block makes up an errored closing beat of its own.

While the enable is low, the source is always ready and every beat it offers is discarded. After the enable returns, nothing passes until a beat with a start marker opens a fresh frame.

A single output register stage decouples the two sides. It holds its contents under backpressure.

Top module: `frame_guard`

## Requirements
- R1: With the port enabled and no frame open, an input beat that has both start and end markers set is forwarded as a one-beat frame. Its data, byte enables and error flag are unchanged, with sop=1 and eop=1.
- R2: A frame that is opened by a start beat and closed by an end beat is forwarded beat for beat, in order, with data and byte enables intact. Only the first beat has sop=1 and only the last beat has eop=1.
- R3: While no frame is open, input beats without a start marker are accepted (in_ready high when the output slot is free) and produce no output.
- R4: A start beat arriving while a frame is open is appended to that frame with sop=0. That beat, and every later beat up to and including the next end beat, has err=1.
- R5: An input beat with in_err=1 sets err on that output beat and on every later beat of the same frame. The next frame starts with a clear flag.
- R6: If rx_en is low in any cycle while a frame is open, the block emits one made-up beat with sop=0, eop=1, err=1, out_be=0 and out_data=0. The beat follows any beat already waiting in the output register, and it is also emitted when the source has stopped sending.
- R7: While rx_en is low, in_ready is 1 and every beat offered is discarded without reaching the output.
- R8: After rx_en returns high, beats without a start marker are discarded until a start beat opens a new frame.
- R9: While out_valid=1 and out_ready=0, every output signal holds its value into the next cycle. No beat is lost or repeated, including the made-up closing beat.
- R10: Downstream framing is always well formed: a beat with sop=1 is seen only when no frame is open, and a beat with sop=0 only inside an open frame.
- R11: During reset and in the first cycle after it, out_valid is 0. With rx_en=1 and out_ready=1, in_ready is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable for the port |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted |
| in_data | input | DATA_W | Upstream beat data |
| in_be | input | DATA_W/8 | Upstream byte enables |
| in_sop | input | 1 | Upstream start-of-packet marker |
| in_eop | input | 1 | Upstream end-of-packet marker |
| in_err | input | 1 | Upstream error flag |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Downstream beat data |
| out_be | output | DATA_W/8 | Downstream byte enables, zero on a made-up closing beat |
| out_sop | output | 1 | Downstream start marker |
| out_eop | output | 1 | Downstream end marker |
| out_err | output | 1 | Downstream error flag, sticky within a frame |

## Verification
The hardest case to reach from the ports is a made-up closing beat that must queue behind a real beat already held in the output register by backpressure.

The bench reaches it as follows:
- It opens a frame with out_ready held low.
- It withdraws rx_en for several cycles, so the guard waits for its closing beat with the slot occupied.
- It then releases backpressure and checks the order, content and stability of both beats.

A near-exhaustive sweep adds the other corner cases. It covers every combination of markers and error flags over three-beat sequences, with enable pulses at varying points and a pseudo-random ready pattern, and compares each beat against a model built from the requirements.

// File: rtl/frame_guard_pkg.sv
package frame_guard_pkg;

    // Width of one byte lane; the byte-enable width is derived from it.
    localparam int unsigned LANE_W = 8;

    typedef enum logic [1:0] {
        FG_IDLE  = 2'd0,   // waiting for a start beat
        FG_OPEN  = 2'd1,   // frame in progress downstream
        FG_ABORT = 2'd2,   // closing beat owed downstream
        FG_DROP  = 2'd3    // port disabled, input sunk
    } fg_state_e;

    typedef struct packed {
        fg_state_e state;
        logic      err;    // sticky error for the open frame
    } fg_seq_t;

endpackage

// File: rtl/fg_sequencer.sv
module fg_sequencer
    import frame_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_eop,
    input  logic in_err,
    input  logic slot_free,
    output logic in_ready,
    output logic take,
    output logic inject,
    output logic beat_sop,
    output logic beat_eop,
    output logic beat_err
);

    fg_seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        in_ready = 1'b0;
        take     = 1'b0;
        inject   = 1'b0;
        beat_sop = 1'b0;
        beat_eop = 1'b0;
        beat_err = 1'b0;

        if (!rx_en) begin
            // Disabled: sink everything, settle any open frame.
            in_ready = 1'b1;
            unique case (seq_q.state)
                FG_OPEN: begin
                    seq_d.state = FG_ABORT;
                end
                FG_ABORT: begin
                    if (slot_free) begin
                        inject      = 1'b1;
                        beat_eop    = 1'b1;
                        beat_err    = 1'b1;
                        seq_d.state = FG_DROP;
                        seq_d.err   = 1'b0;
                    end
                end
                default: begin
                    seq_d.state = FG_DROP;
                    seq_d.err   = 1'b0;
                end
            endcase
        end else begin
            unique case (seq_q.state)
                FG_IDLE: begin
                    in_ready = slot_free;
                    if (in_valid && slot_free && in_sop) begin
                        take        = 1'b1;
                        beat_sop    = 1'b1;
                        beat_eop    = in_eop;
                        beat_err    = in_err;
                        seq_d.state = in_eop ? FG_IDLE : FG_OPEN;
                        seq_d.err   = in_eop ? 1'b0 : in_err;
                    end
                end
                FG_OPEN: begin
                    in_ready = slot_free;
                    if (in_valid && slot_free) begin
                        // A second start inside a frame is merged and marked.
                        take        = 1'b1;
                        beat_sop    = 1'b0;
                        beat_eop    = in_eop;
                        beat_err    = seq_q.err | in_err | in_sop;
                        seq_d.state = in_eop ? FG_IDLE : FG_OPEN;
                        seq_d.err   = in_eop ? 1'b0 : (seq_q.err | in_err | in_sop);
                    end
                end
                FG_ABORT: begin
                    // Closing beat still owed; hold the source off.
                    if (slot_free) begin
                        inject      = 1'b1;
                        beat_eop    = 1'b1;
                        beat_err    = 1'b1;
                        seq_d.state = FG_IDLE;
                        seq_d.err   = 1'b0;
                    end
                end
                default: begin
                    seq_d.state = FG_IDLE;
                    seq_d.err   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: FG_IDLE, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/fg_beat_mux.sv
module fg_beat_mux
    import frame_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                     inject,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W/LANE_W-1:0] in_be,
    output logic [DATA_W-1:0]        beat_data,
    output logic [DATA_W/LANE_W-1:0] beat_be
);

    localparam int unsigned BE_W = DATA_W / LANE_W;

    // A made-up closing beat carries no payload: clear every lane.
    for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
        assign beat_data[lane*LANE_W +: LANE_W] =
            inject ? '0 : in_data[lane*LANE_W +: LANE_W];
        assign beat_be[lane] = inject ? 1'b0 : in_be[lane];
    end

endmodule

// File: rtl/fg_out_stage.sv
module fg_out_stage
    import frame_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [DATA_W-1:0]        ld_data,
    input  logic [DATA_W/LANE_W-1:0] ld_be,
    input  logic                     ld_sop,
    input  logic                     ld_eop,
    input  logic                     ld_err,
    output logic                     slot_free,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic [DATA_W/LANE_W-1:0] out_be,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic                     out_err
);

    localparam int unsigned BE_W = DATA_W / LANE_W;

    typedef struct packed {
        logic              v;
        logic              sop;
        logic              eop;
        logic              err;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_free = !slot_q.v || out_ready;
        slot_d    = slot_q;
        if (load) begin
            slot_d.v    = 1'b1;
            slot_d.sop  = ld_sop;
            slot_d.eop  = ld_eop;
            slot_d.err  = ld_err;
            slot_d.be   = ld_be;
            slot_d.data = ld_data;
        end else if (out_ready) begin
            slot_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.v;
    assign out_data  = slot_q.data;
    assign out_be    = slot_q.be;
    assign out_sop   = slot_q.sop;
    assign out_eop   = slot_q.eop;
    assign out_err   = slot_q.err;

endmodule

// File: rtl/frame_guard.sv
module frame_guard
    import frame_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_en,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W/LANE_W-1:0] in_be,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic                     in_err,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic [DATA_W/LANE_W-1:0] out_be,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic                     out_err
);

    localparam int unsigned BE_W = DATA_W / LANE_W;

    logic              slot_free;
    logic              take;
    logic              inject;
    logic              beat_sop;
    logic              beat_eop;
    logic              beat_err;
    logic [DATA_W-1:0] beat_data;
    logic [BE_W-1:0]   beat_be;

    fg_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_err    (in_err),
        .slot_free (slot_free),
        .in_ready  (in_ready),
        .take      (take),
        .inject    (inject),
        .beat_sop  (beat_sop),
        .beat_eop  (beat_eop),
        .beat_err  (beat_err)
    );

    fg_beat_mux #(.DATA_W(DATA_W)) u_mux (
        .inject    (inject),
        .in_data   (in_data),
        .in_be     (in_be),
        .beat_data (beat_data),
        .beat_be   (beat_be)
    );

    fg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take | inject),
        .ld_data   (beat_data),
        .ld_be     (beat_be),
        .ld_sop    (beat_sop),
        .ld_eop    (beat_eop),
        .ld_err    (beat_err),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_err)
    );

endmodule

// File: rtl/frame_guard_chk.sv
module frame_guard_chk
    import frame_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rx_en,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [DATA_W-1:0]        out_data,
    input logic [DATA_W/LANE_W-1:0] out_be,
    input logic                     out_sop,
    input logic                     out_eop,
    input logic                     out_err
);

    // Tracks whether a frame is open on the downstream side.
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            open_q <= !out_eop;
        end
    end

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)
                                    && $stable(out_sop) && $stable(out_eop) && $stable(out_err));

    // R7
    sink_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> in_ready);

    // R10
    sop_only_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> !open_q);

    // R10
    body_only_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop |-> open_q);

    // R11
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind frame_guard frame_guard_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_frame_guard.sv
`timescale 1ns/1ps
module sim_frame_guard;

    localparam int DW = 32;
    localparam int BW = DW / 8;

    typedef struct packed {
        logic          sop;
        logic          eop;
        logic          err;
        logic [BW-1:0] be;
        logic [DW-1:0] data;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [BW-1:0] in_be = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          in_err = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic [BW-1:0] out_be;
    logic          out_sop;
    logic          out_eop;
    logic          out_err;

    always #4 clk = ~clk;   // 125 MHz

    frame_guard #(.DATA_W(DW)) u0 (.*);

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R11";

    // Next-cycle drive values.
    logic          nx_valid = 1'b0, nx_sop = 1'b0, nx_eop = 1'b0, nx_err = 1'b0, nx_rx = 1'b1;
    logic [DW-1:0] nx_data = '0;
    logic [BW-1:0] nx_be = '0;
    int            rdy_mode = 0;   // 0 always ready, 1 pseudo-random, 2 stalled
    logic [15:0]   lfsr = 16'hACE1;

    // Reference model state.
    beat_t exp_q[$];
    logic  m_open = 1'b0;
    logic  m_err = 1'b0;
    logic  down_open = 1'b0;
    logic  prev_hold = 1'b0;
    beat_t prev_beat;
    logic  in_fire = 1'b0;
    logic [DW-1:0] tag = 32'h1000_0000;

    task automatic fail_line(string req, string what, logic [63:0] act, logic [63:0] expv);
        fails++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    endtask

    task automatic cycle();
        beat_t ob;
        beat_t eb;
        beat_t synth;
        logic  e;
        @(negedge clk);
        in_valid = nx_valid; in_sop = nx_sop; in_eop = nx_eop; in_err = nx_err;
        in_data = nx_data; in_be = nx_be; rx_en = nx_rx;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
        #1;
        ob = '{sop: out_sop, eop: out_eop, err: out_err, be: out_be, data: out_data};
        // R9: held beat must not change
        if (prev_hold) begin
            checks++;
            if (!out_valid || ob != prev_beat)
                fail_line("R9", "held beat changed", {23'd0, out_valid, ob}, {23'd0, 1'b1, prev_beat});
        end
        prev_hold = out_valid && !out_ready;
        prev_beat = ob;
        // R7: always ready while disabled
        if (!rx_en) begin
            checks++;
            if (!in_ready) fail_line("R7", "in_ready low while disabled", 64'(in_ready), 64'd1);
        end
        in_fire = in_valid && in_ready;
        // Output side first.
        if (out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fail_line(cur_req, "unexpected output beat", 64'(ob), 64'd0);
            end else begin
                eb = exp_q.pop_front();
                if (ob != eb)
                    fail_line((eb.be == '0) ? "R6" : cur_req, "beat mismatch", 64'(ob), 64'(eb));
            end
            // R10: downstream framing
            checks++;
            if (out_sop == down_open)
                fail_line("R10", "sop vs open frame", 64'(out_sop), 64'(!down_open));
            down_open = !out_eop;
        end
        // Model update from the requirements.
        if (!rx_en) begin
            if (m_open) begin
                synth = '{sop: 1'b0, eop: 1'b1, err: 1'b1, be: '0, data: '0};
                exp_q.push_back(synth);   // R6
                m_open = 1'b0;
                m_err  = 1'b0;
            end
        end else if (in_fire) begin
            if (!m_open) begin
                if (in_sop) begin
                    exp_q.push_back('{sop: 1'b1, eop: in_eop, err: in_err, be: in_be, data: in_data});
                    m_open = !in_eop;
                    m_err  = in_eop ? 1'b0 : in_err;
                end
            end else begin
                e = m_err | in_err | in_sop;   // R4, R5
                exp_q.push_back('{sop: 1'b0, eop: in_eop, err: e, be: in_be, data: in_data});
                m_open = !in_eop;
                m_err  = in_eop ? 1'b0 : e;
            end
        end
    endtask

    task automatic send(logic s, logic e, logic r, logic [BW-1:0] be);
        tag = tag + 1;
        nx_valid = 1'b1; nx_sop = s; nx_eop = e; nx_err = r;
        nx_data = tag; nx_be = (be == '0) ? 4'h1 : be;
        for (int n = 0; n < 500; n++) begin
            cycle();
            if (in_fire) break;
        end
        nx_valid = 1'b0; nx_sop = 1'b0; nx_eop = 1'b0; nx_err = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic drain();
        if (rdy_mode == 2) rdy_mode = 1;
        for (int k = 0; k < 200; k++) begin
            cycle();
            if (exp_q.size() == 0 && !out_valid) break;
        end
        checks++;
        if (exp_q.size() != 0)
            fail_line(cur_req, "expected beats never delivered", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic disable_for(int n);
        nx_rx = 1'b0;
        idle(n);
        nx_rx = 1'b1;
    endtask

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails + 1);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        idle(3);
        checks++;
        if (out_valid !== 1'b0) fail_line("R11", "out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        checks++;
        if (out_valid !== 1'b0) fail_line("R11", "out_valid after reset", 64'(out_valid), 64'd0);
        checks++;
        if (in_ready !== 1'b1) fail_line("R11", "in_ready after reset", 64'(in_ready), 64'd1);

        // R1: one-beat frames, clean and errored
        cur_req = "R1";
        send(1, 1, 0, 4'hF);
        send(1, 1, 1, 4'h3);
        drain();

        // R2: multi-beat frames under varied backpressure
        cur_req = "R2";
        rdy_mode = 1;
        for (int len = 2; len <= 5; len++) begin
            send(1, 0, 0, 4'hF);
            for (int b = 1; b < len - 1; b++) send(0, 0, 0, 4'hF);
            send(0, 1, 0, 4'h7);
        end
        drain();
        rdy_mode = 0;

        // R3: stray beats with no frame open
        cur_req = "R3";
        send(0, 0, 0, 4'hF);
        send(0, 1, 1, 4'hF);
        send(0, 0, 0, 4'h1);
        drain();

        // R4: missing end marker, then a new start
        cur_req = "R4";
        send(1, 0, 0, 4'hF);
        send(0, 0, 0, 4'hF);
        send(1, 0, 0, 4'hF);
        send(0, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        send(1, 1, 0, 4'hF);   // clean frame after merge
        drain();

        // R5: error mid-frame is sticky, next frame clean
        cur_req = "R5";
        send(1, 0, 0, 4'hF);
        send(0, 0, 1, 4'hF);
        send(0, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        send(1, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        drain();

        // R6: source stalls mid-frame; disable releases it
        cur_req = "R6";
        send(1, 0, 0, 4'hF);
        send(0, 0, 0, 4'hF);
        idle(4);
        disable_for(3);
        drain();

        // R6 + R9: closing beat queued behind a held beat
        rdy_mode = 2;
        send(1, 0, 0, 4'hF);
        nx_rx = 1'b0;
        idle(4);
        rdy_mode = 0;
        idle(4);
        nx_rx = 1'b1;
        drain();

        // R7: beats offered while disabled vanish
        cur_req = "R7";
        nx_rx = 1'b0;
        send(1, 1, 0, 4'hF);
        send(1, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        nx_rx = 1'b1;
        drain();

        // R8: re-enable in the middle of an old frame
        cur_req = "R8";
        send(1, 0, 0, 4'hF);
        disable_for(2);
        send(0, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        send(1, 0, 0, 4'hF);
        send(0, 1, 0, 4'hF);
        drain();

        // Sweep: every marker/error combination over three beats
        cur_req = "R10";
        for (int idx = 0; idx < 512; idx++) begin
            rdy_mode = (idx % 3 == 0) ? 0 : 1;
            for (int b = 0; b < 3; b++) begin
                send(idx[3*b+2], idx[3*b+1], idx[3*b], 4'((idx + b) | 1));
                if (b == 1 && (idx % 7 == 3)) disable_for(1 + idx % 3);
            end
        end
        disable_for(2);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule